// File: doc/BRIEF.md
# Clock Watchdog and Error Register Unit

This block watches eight timing-bus clock lines and two network reference lines. Each line has its own watchdog counter. The counter runs on the state-machine clock, and a synchronized rising edge on the line restarts it. A line counts as failing once its counter reaches a limit that software can set. A per-line enable register gates what gets reported. Unmasked clock failures go to a sticky register and to a live-status register, and both use the same bit-per-line mapping as the enable register.

Failures and lookup or write faults from the three connection-memory banks (even, odd and local) are gathered into a sticky system error byte. Its bit 0 is a fallback flag. It is set only when an enabled clock that belongs to the currently selected clocking mode fails. Software clears the sticky registers through a control address. The internal clear pulse starts one cycle after the write strobe falls, and it forces the targets to zero asynchronously.

Top module: `clkmon_err_unit`

Register addresses (3-bit `addr`): 0 sticky clock errors (read only), 1 live clock errors (read only), 2 watchdog enable, 3 reference byte, 4 system errors (read only), 5 mode select (bits 1:0), 6 clear control (write only, reads 0), 7 watchdog limit (reset 20).

## Requirements
- R1: After reset, addresses 0 to 6 read 0x00 and address 7 reads 20.
- R2: A line with no rising edge for at least the limit (address 7) in clock cycles is failing. A line toggling faster than that is not. Live failures of enabled clock lines appear at address 1, bit i for clock line i.
- R3: A failure on clock line i while enable bit i (address 2) is 0 is not reported at address 0 or 1, and does not set the fallback flag.
- R4: Bits at address 0 stay set after the line recovers until cleared, while the address 1 bit drops.
- R5: A write to address 6 with bit 0 set clears address 0, and with bit 1 set clears address 4. The clear takes effect one clock cycle after the cycle in which the write strobe falls, and not before.
- R6: At address 3, bits 3:0 are read/write and bits 7:6 read 0. Writes to bits 7:4 are ignored. Bit 4 shows a live failure of reference line 0. Bit 5 shows a live failure of reference line 1, but only while bit 0 is 1.
- R7: At address 4, one-cycle underflow events for the even, odd and local banks set bits 7, 6 and 5. Overflow events for the same banks set bits 4, 3 and 2. The bits are sticky, and bit 1 reads 0.
- R8: Address 4 bit 0 is set (sticky) only by an enabled failing clock in the set picked by address 5. The sets are: mode 0 lines 0 and 1, mode 1 lines 2 to 4, mode 2 lines 5 and 6, mode 3 line 7. Failures outside that set leave it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State-machine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_lines | input | 8 | Monitored timing clock lines |
| ref_lines | input | 2 | Monitored network reference lines |
| uflow_ev | input | 3 | Bank underflow events [2]=even [1]=odd [0]=local |
| oflow_ev | input | 3 | Bank overflow events [2]=even [1]=odd [0]=local |
| wr_stb | input | 1 | Write strobe, active high |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |

## Verification
A stuck watchdog counter shows up at address 1 within about the limit plus three cycles after the line stops or restarts. A lost sticky bit shows up on the next read of address 0 after the line recovers. A clear pulse at the wrong time is caught by reading address 0 in the cycle before and the cycle after the expected pulse. A wrong mode map or wrong masking leaves the fallback bit at address 4 in the wrong state once the watchdog window has passed.

// File: rtl/clkmon_err_unit.sv
module clkmon_err_unit #(
  parameter int          CW       = 8,
  parameter logic [7:0]  DEF_LIM  = 8'd20,
  parameter logic [31:0] MODE_MAP = 32'h80_60_1C_03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] clk_lines,
  input  logic [1:0] ref_lines,
  input  logic [2:0] uflow_ev,
  input  logic [2:0] oflow_ev,
  input  logic       wr_stb,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int NL = 10;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [NL-1:0] s1, s2, s3, rise, fail;
  logic [7:0] wden, stk, syserr, lim, sel_map;
  logic [3:0] nref_rw;
  logic [1:0] mode_sel, clr_pend, clr_q;
  logic       wr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= {ref_lines, clk_lines};
      s2 <= s1;
      s3 <= s2;
    end

  assign rise = s2 & ~s3;

  for (genvar g = 0; g < NL; g++) begin : g_wd
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)            cnt <= '0;
      else if (rise[g])      cnt <= '0;
      else if (cnt != CMAX)  cnt <= cnt + 1'b1;
    assign fail[g] = cnt >= CW'(lim);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wden <= '0; nref_rw <= '0; mode_sel <= '0; lim <= DEF_LIM;
    end else if (wr_stb) begin
      case (addr)
        3'd2: wden     <= wdata;
        3'd3: nref_rw  <= wdata[3:0];
        3'd5: mode_sel <= wdata[1:0];
        3'd7: lim      <= wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_q <= 1'b0; clr_pend <= '0; clr_q <= '0;
    end else begin
      wr_q  <= wr_stb;
      clr_q <= (wr_q && !wr_stb) ? clr_pend : 2'b00;
      if (wr_stb && addr == 3'd6) clr_pend <= wdata[1:0];
      else if (wr_q && !wr_stb)   clr_pend <= '0;
    end

  assign sel_map = MODE_MAP[8*mode_sel +: 8];

  wire stk_rst = !rst_n || clr_q[0];
  wire sys_rst = !rst_n || clr_q[1];
  wire fb_hit  = |(fail[7:0] & wden & sel_map);

  always_ff @(posedge clk or posedge stk_rst)
    if (stk_rst) stk <= '0;
    else         stk <= stk | (fail[7:0] & wden);

  always_ff @(posedge clk or posedge sys_rst)
    if (sys_rst) syserr <= '0;
    else         syserr <= syserr | {uflow_ev, oflow_ev, 1'b0, fb_hit};

  always_comb
    case (addr)
      3'd0: rdata = stk;
      3'd1: rdata = fail[7:0] & wden;
      3'd2: rdata = wden;
      3'd3: rdata = {2'b00, fail[9] & nref_rw[0], fail[8], nref_rw};
      3'd4: rdata = syserr;
      3'd5: rdata = {6'b0, mode_sel};
      3'd6: rdata = 8'h00;
      default: rdata = lim;
    endcase
endmodule

// File: rtl/clkmon_err_chk.sv
module clkmon_err_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] wden,
  input logic [7:0] stk,
  input logic [7:0] syserr,
  input logic [7:0] sel_map,
  input logic [9:0] fail,
  input logic [1:0] clr_q,
  input logic [2:0] uflow_ev
);
  logic rdy, clr_d0;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin rdy <= 1'b0; clr_d0 <= 1'b0; end
    else begin rdy <= 1'b1; clr_d0 <= clr_q[0]; end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !clr_q[0] && !clr_d0) |-> ((stk & $past(stk)) == $past(stk))); // R4
  AST_STICKY_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (((stk & ~$past(stk)) & ~$past(wden)) == 8'h00)); // R3
  AST_CLEAR_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && $past(wr_stb) && !wr_stb && $past(addr) == 3'd6 && $past(wdata[0])) |=> (stk == 8'h00)); // R5
  AST_UFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !clr_q[1] && !$past(clr_q[1])) |-> (($past(uflow_ev) & ~syserr[7:5]) == 3'b000)); // R7
  AST_FALLBACK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && $rose(syserr[0])) |-> $past(|(fail[7:0] & wden & sel_map))); // R8
endmodule

bind clkmon_err_unit clkmon_err_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
  .wden(wden), .stk(stk), .syserr(syserr), .sel_map(sel_map), .fail(fail),
  .clr_q(clr_q), .uflow_ev(uflow_ev)
);

// File: tb/clkmon_err_unit_test.sv
module clkmon_err_unit_test;
  logic clk = 0, rst_n = 0, wr_stb = 0;
  logic [2:0] addr = 0, uflow_ev = 0, oflow_ev = 0;
  logic [7:0] wdata = 0, rdata;
  logic [9:0] lines = 0, run = 10'h3FF;
  int tick = 0, total = 0, bad = 0;

  always #2 clk = ~clk;

  clkmon_err_unit uut (
    .clk(clk), .rst_n(rst_n), .clk_lines(lines[7:0]), .ref_lines(lines[9:8]),
    .uflow_ev(uflow_ev), .oflow_ev(oflow_ev), .wr_stb(wr_stb), .addr(addr),
    .wdata(wdata), .rdata(rdata)
  );

  always @(negedge clk) begin
    tick <= (tick == 2) ? 0 : tick + 1;
    if (tick == 2) lines <= (lines ^ run);
  end

  task automatic chk(input string r, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", r, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_stb = 1;
    @(negedge clk); wr_stb = 0;
    cyc(3);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic rdchk(input string r, input logic [2:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v); chk(r, v, e);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 7; i++) rdchk("R1", 3'(i), 8'h00);
    rdchk("R1 limit", 3'd7, 8'd20);
  endtask

  task automatic t_watchdog;
    wr(3'd2, 8'hFF);
    cyc(60);
    rdchk("R2 running", 3'd1, 8'h00);
    wr(3'd7, 8'd60);
    run[3] = 0;
    cyc(35);
    rdchk("R2 before limit", 3'd1, 8'h00);
    cyc(45);
    rdchk("R2 after limit", 3'd1, 8'h08);
    wr(3'd7, 8'd20);
  endtask

  task automatic t_sticky;
    run[3] = 1;
    cyc(30);
    rdchk("R4 live drop", 3'd1, 8'h00);
    rdchk("R4 sticky", 3'd0, 8'h08);
  endtask

  task automatic t_clear;
    logic [7:0] v;
    @(negedge clk); addr = 3'd6; wdata = 8'h01; wr_stb = 1;
    @(negedge clk); wr_stb = 0; addr = 3'd0; #1 v = rdata;
    chk("R5 not early", v, 8'h08);
    @(negedge clk); #1 v = rdata;
    chk("R5 cleared", v, 8'h00);
    cyc(5);
    rdchk("R5 stays", 3'd0, 8'h00);
  endtask

  task automatic t_mask;
    wr(3'd2, 8'hFD);
    run[1] = 0;
    cyc(45);
    rdchk("R3 sticky", 3'd0, 8'h00);
    rdchk("R3 live", 3'd1, 8'h00);
    rdchk("R3 fallback", 3'd4, 8'h00);
    run[1] = 1;
    cyc(30);
    wr(3'd2, 8'hFF);
  endtask

  task automatic t_fallback;
    run[5] = 0;
    cyc(45);
    rdchk("R8 other line flagged", 3'd0, 8'h20);
    rdchk("R8 out of mode", 3'd4, 8'h00);
    run[5] = 1; run[1] = 0;
    cyc(45);
    rdchk("R8 in mode", 3'd4, 8'h01);
    wr(3'd5, 8'h01);
    wr(3'd6, 8'h03);
    cyc(10);
    rdchk("R8 mode1 ignores line1", 3'd4, 8'h00);
    run[2] = 0;
    cyc(45);
    rdchk("R8 mode1 line2", 3'd4, 8'h01);
    run[1] = 1; run[2] = 1;
    cyc(30);
    wr(3'd5, 8'h00);
    wr(3'd6, 8'h03);
    rdchk("R5 both cleared", 3'd4, 8'h00);
  endtask

  task automatic t_ref;
    wr(3'd3, 8'hFF);
    rdchk("R6 rw bits", 3'd3, 8'h0F);
    run[9:8] = 0;
    cyc(45);
    rdchk("R6 both fail", 3'd3, 8'h3F);
    wr(3'd3, 8'h00);
    rdchk("R6 ref1 gated", 3'd3, 8'h10);
    run[9:8] = 2'b11;
    cyc(30);
    rdchk("R6 recovered", 3'd3, 8'h00);
  endtask

  task automatic t_cam;
    @(negedge clk); uflow_ev = 3'b100;
    @(negedge clk); uflow_ev = 0;
    rdchk("R7 even under", 3'd4, 8'h80);
    @(negedge clk); oflow_ev = 3'b001;
    @(negedge clk); oflow_ev = 0;
    rdchk("R7 local over", 3'd4, 8'h84);
    @(negedge clk); uflow_ev = 3'b011; oflow_ev = 3'b110;
    @(negedge clk); uflow_ev = 0; oflow_ev = 0;
    cyc(10);
    rdchk("R7 all sticky", 3'd4, 8'hFC);
    wr(3'd6, 8'h02);
    rdchk("R7 cleared", 3'd4, 8'h00);
  endtask

  initial begin
    cyc(5); rst_n = 1; cyc(2);
    t_reset;
    t_watchdog;
    t_sticky;
    t_clear;
    t_mask;
    t_fallback;
    t_ref;
    t_cam;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog timeout");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule